// File: doc/BRIEF.md
# Ready/Busy and Hardware Reset Controller

This block follows the state of the on-chip program/erase engine and drives the device's ready/busy line. The line is modelled as an open-drain pull-down enable: when `rb_pulldown` is high the line is pulled low (busy). While an operation runs, new program or erase commands are refused. The one request still honoured is erase suspend. A suspended erase releases the line and can be resumed with a new start strobe.

The same block owns the hardware reset pin. A low pulse takes effect only once it has been sampled low for `MIN_PULSE` cycles; a shorter glitch is dropped and the controller returns to the state it was in. An accepted reset holds the controller in reset until the pin rises, then times a recovery window whose length depends on what was interrupted. Idle (read/standby) gets `T_SHORT` cycles. Program, erase or a suspended erase gets `T_LONG` cycles, with the ready/busy line kept low throughout, and the interrupted data is flagged as corrupt.

When the pin is held at its raised voltage level, reported on a separate flag, the block asserts an override that lets protected blocks be written. Both pin inputs pass through a `SYNC_STAGES`-deep synchronizer.

States: `ST_IDLE` (read/standby), `ST_PROG`, `ST_ERASE`, `ST_SUSP`, `ST_QUAL` (pin low, width being qualified), `ST_HOLD` (reset accepted, pin still low) and `ST_RECOVER` (pin high, recovery timing). Transitions:
- IDLE→PROG/ERASE on start.
- PROG/ERASE→IDLE on done.
- ERASE→SUSP on suspend request.
- SUSP→ERASE on start.
- any of IDLE/PROG/ERASE/SUSP→QUAL on pin low.
- QUAL→origin on pin high before the width is met.
- QUAL→HOLD on the width being met.
- HOLD→RECOVER on pin high.
- RECOVER→HOLD on pin low.
- RECOVER→IDLE when the timer expires.

Top module: `pe_ready_reset_ctrl`

## Requirements
- R1: After `rst_n` is released, `rb_pulldown`=0, `cmd_accept`=1, `reset_busy`=0, `data_corrupt`=0 and `unprot_ovr`=0.
- R2: A start strobe accepted while idle (`pe_is_erase`=1 selects erase, 0 selects program) sets `rb_pulldown` on the next cycle. It stays set until `pe_done`, which releases it on the next cycle.
- R3: While a program or erase is running, `cmd_accept` is 0 and further start strobes have no effect.
- R4: `susp_req` during an erase releases `rb_pulldown` and raises `cmd_accept` on the next cycle, and a start strobe then resumes the erase. `susp_req` during a program has no effect.
- R5: A reset pin pulse sampled low for fewer than `MIN_PULSE` cycles is ignored. Afterwards the state and all outputs are as before, and `reset_busy` never rises.
- R6: A reset of L ≥ `MIN_PULSE` low samples taken while idle raises `reset_busy` for exactly L−`MIN_PULSE`+1+`T_SHORT` cycles, with `rb_pulldown` at 0 throughout.
- R7: A reset of L ≥ `MIN_PULSE` low samples taken during program, erase or erase suspend raises `reset_busy` for exactly L−`MIN_PULSE`+1+`T_LONG` cycles. `rb_pulldown` is 1 throughout and falls in the same cycle as `reset_busy`.
- R8: A reset accepted during program, erase or erase suspend sets `data_corrupt`. It stays set until the next accepted start strobe clears it.
- R9: `cmd_accept` is 0 whenever `reset_busy` is 1.
- R10: `unprot_ovr` follows the synchronized raised-level flag while no reset is in progress, and is 0 whenever `reset_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the controller logic |
| pe_start | input | 1 | Start strobe from the command decoder (also resumes a suspended erase) |
| pe_is_erase | input | 1 | With `pe_start`: 1 = erase, 0 = program |
| pe_done | input | 1 | Completion strobe from the program/erase engine |
| susp_req | input | 1 | Erase suspend request |
| rp_pin_n | input | 1 | Hardware reset pin, active low, asynchronous |
| rp_hv | input | 1 | Reset pin is at its raised voltage level, asynchronous |
| rb_pulldown | output | 1 | Open-drain enable: 1 pulls ready/busy low (busy) |
| cmd_accept | output | 1 | 1 when a start strobe would be accepted |
| reset_busy | output | 1 | Accepted reset or its recovery in progress |
| data_corrupt | output | 1 | An operation was cut short by a reset |
| unprot_ovr | output | 1 | Temporary override of block protection |

## Verification
The checker enforces, every cycle:
- command refusal while busy or in reset;
- that a start strobe taken with the pin high makes the device busy next cycle;
- the stickiness of the corrupt flag;
- that ready/busy and the reset indication release together after a long recovery;
- that the protection override is never active during reset.

Only the bench's scenarios can show the parts that depend on pulse length and history:
- the exact recovery lengths for short and long resets;
- that a glitch below the minimum width leaves a running program untouched;
- the suspend/resume sequence;
- the synchronizer latency of the raised-level flag.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_SUSP,
        ST_QUAL,
        ST_HOLD,
        ST_RECOVER
    } rrc_state_e;

    // States in which a reset counts as interrupting array work.
    function automatic logic is_pe_active(input rrc_state_e st);
        return (st == ST_PROG) || (st == ST_ERASE) || (st == ST_SUSP);
    endfunction

    // States in which the engine is actively running.
    function automatic logic is_running(input rrc_state_e st);
        return (st == ST_PROG) || (st == ST_ERASE);
    endfunction

endpackage

// File: rtl/rrc_sync.sv
module rrc_sync #(
    parameter int WIDTH = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= {STAGES{RST_VAL[b]}};
                end else if (STAGES == 1) begin
                    chain <= d[b];
                end else begin
                    chain <= {chain[STAGES-2:0], d[b]};
                end
            end
            assign q[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rrc_downcnt.sv
module rrc_downcnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         zero
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/pe_ready_reset_ctrl.sv
module pe_ready_reset_ctrl
    import rrc_pkg::*;
#(
    parameter int MIN_PULSE   = 4,
    parameter int T_SHORT     = 3,
    parameter int T_LONG      = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pe_start,
    input  logic pe_is_erase,
    input  logic pe_done,
    input  logic susp_req,
    input  logic rp_pin_n,
    input  logic rp_hv,
    output logic rb_pulldown,
    output logic cmd_accept,
    output logic reset_busy,
    output logic data_corrupt,
    output logic unprot_ovr
);

    localparam int MAX_REC = (T_LONG > T_SHORT) ? T_LONG : T_SHORT;
    localparam int MAX_ALL = (MAX_REC > MIN_PULSE) ? MAX_REC : MIN_PULSE;
    localparam int CNT_W   = $clog2(MAX_ALL + 1);

    localparam logic [CNT_W-1:0] LD_QUAL  = CNT_W'(MIN_PULSE - 1);
    localparam logic [CNT_W-1:0] LD_SHORT = CNT_W'(T_SHORT - 1);
    localparam logic [CNT_W-1:0] LD_LONG  = CNT_W'(T_LONG - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    initial begin
        if (MIN_PULSE < 2 || T_SHORT < 1 || T_LONG < 1 || SYNC_STAGES < 1)
            $display("pe_ready_reset_ctrl: parameter out of range");
    end

    // Pin synchronizer: bit 0 = reset pin (idles high), bit 1 = raised level flag.
    logic pin_s;
    logic hv_s;

    rrc_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b01)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({rp_hv, rp_pin_n}),
        .q    ({hv_s, pin_s})
    );

    // Single shared down-counter for pulse qualification and recovery.
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_zero;

    rrc_downcnt #(
        .W(CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .cnt     (tmr_cnt),
        .zero    (tmr_zero)
    );

    rrc_state_e state_q, state_d;
    rrc_state_e ret_q, ret_d;
    logic       long_q, long_d;
    logic       corrupt_q, corrupt_d;
    rrc_state_e ret_eff;

    // A completion seen while a pulse is being qualified still finishes the operation.
    always_comb begin
        ret_eff = ret_q;
        if (pe_done && is_running(ret_q)) ret_eff = ST_IDLE;
    end

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        ret_d     = ret_q;
        long_d    = long_q;
        corrupt_d = corrupt_q;
        tmr_load  = 1'b0;
        tmr_val   = LD_QUAL;

        unique case (state_q)
            ST_IDLE: begin
                if (!pin_s) begin
                    state_d  = ST_QUAL;
                    ret_d    = state_q;
                    tmr_load = 1'b1;
                end else if (pe_start) begin
                    state_d   = pe_is_erase ? ST_ERASE : ST_PROG;
                    corrupt_d = 1'b0;
                end
            end
            ST_PROG: begin
                if (!pin_s) begin
                    state_d  = ST_QUAL;
                    ret_d    = state_q;
                    tmr_load = 1'b1;
                end else if (pe_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_ERASE: begin
                if (!pin_s) begin
                    state_d  = ST_QUAL;
                    ret_d    = state_q;
                    tmr_load = 1'b1;
                end else if (pe_done) begin
                    state_d = ST_IDLE;
                end else if (susp_req) begin
                    state_d = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (!pin_s) begin
                    state_d  = ST_QUAL;
                    ret_d    = state_q;
                    tmr_load = 1'b1;
                end else if (pe_start) begin
                    state_d   = ST_ERASE;
                    corrupt_d = 1'b0;
                end
            end
            ST_QUAL: begin
                ret_d = ret_eff;
                if (pin_s) begin
                    state_d = ret_eff;
                end else if (tmr_cnt == CNT_ONE) begin
                    state_d = ST_HOLD;
                    long_d  = is_pe_active(ret_eff);
                    if (is_pe_active(ret_eff)) corrupt_d = 1'b1;
                end
            end
            ST_HOLD: begin
                if (pin_s) begin
                    state_d  = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = long_q ? LD_LONG : LD_SHORT;
                end
            end
            ST_RECOVER: begin
                if (!pin_s) begin
                    state_d = ST_HOLD;
                end else if (tmr_zero) begin
                    state_d = ST_IDLE;
                    long_d  = 1'b0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ret_q     <= ST_IDLE;
            long_q    <= 1'b0;
            corrupt_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            ret_q     <= ret_d;
            long_q    <= long_d;
            corrupt_q <= corrupt_d;
        end
    end

    // Outputs
    always_comb begin
        rb_pulldown  = 1'b0;
        cmd_accept   = 1'b0;
        reset_busy   = 1'b0;
        unprot_ovr   = 1'b0;
        data_corrupt = corrupt_q;

        unique case (state_q)
            ST_IDLE: begin
                cmd_accept = 1'b1;
                unprot_ovr = hv_s;
            end
            ST_PROG, ST_ERASE: begin
                rb_pulldown = 1'b1;
                unprot_ovr  = hv_s;
            end
            ST_SUSP: begin
                cmd_accept = 1'b1;
                unprot_ovr = hv_s;
            end
            ST_QUAL: begin
                rb_pulldown = is_running(ret_q);
            end
            ST_HOLD, ST_RECOVER: begin
                reset_busy  = 1'b1;
                rb_pulldown = long_q;
            end
            default: begin
                rb_pulldown = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rrc_chk.sv
module rrc_chk (
    input logic clk,
    input logic rst_n,
    input logic pin_s,
    input logic pe_start,
    input logic cmd_accept,
    input logic rb_pulldown,
    input logic reset_busy,
    input logic data_corrupt,
    input logic unprot_ovr
);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_start && cmd_accept && pin_s) |=> rb_pulldown);

    assert_busy_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_pulldown && !reset_busy) |-> !cmd_accept);

    assert_release_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rb_pulldown) && $past(reset_busy)) |-> $fell(reset_busy));

    assert_corrupt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_corrupt && !(pe_start && cmd_accept)) |=> data_corrupt);

    assert_reset_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_busy |-> !cmd_accept);

    assert_unprot_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        unprot_ovr |-> !reset_busy);

endmodule

bind pe_ready_reset_ctrl rrc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_s       (pin_s),
    .pe_start    (pe_start),
    .cmd_accept  (cmd_accept),
    .rb_pulldown (rb_pulldown),
    .reset_busy  (reset_busy),
    .data_corrupt(data_corrupt),
    .unprot_ovr  (unprot_ovr)
);

// File: tb/tb_pe_ready_reset_ctrl.sv
module tb_pe_ready_reset_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int MIN_PULSE  = 4;
    localparam int T_SHORT    = 3;
    localparam int T_LONG     = 20;
    localparam int SYNC       = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pe_start = 1'b0, pe_is_erase = 1'b0, pe_done = 1'b0, susp_req = 1'b0;
    logic rp_pin_n = 1'b1, rp_hv = 1'b0;
    logic rb_pulldown, cmd_accept, reset_busy, data_corrupt, unprot_ovr;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    typedef struct {
        int len;
        bit rb;
    } exp_run_t;
    exp_run_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pe_ready_reset_ctrl #(
        .MIN_PULSE  (MIN_PULSE),
        .T_SHORT    (T_SHORT),
        .T_LONG     (T_LONG),
        .SYNC_STAGES(SYNC)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pe_start    (pe_start),
        .pe_is_erase (pe_is_erase),
        .pe_done     (pe_done),
        .susp_req    (susp_req),
        .rp_pin_n    (rp_pin_n),
        .rp_hv       (rp_hv),
        .rb_pulldown (rb_pulldown),
        .cmd_accept  (cmd_accept),
        .reset_busy  (reset_busy),
        .data_corrupt(data_corrupt),
        .unprot_ovr  (unprot_ovr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_start(input bit erase);
        pe_start = 1'b1; pe_is_erase = erase;
        cyc(1);
        pe_start = 1'b0; pe_is_erase = 1'b0;
    endtask

    task automatic strobe_done();
        pe_done = 1'b1; cyc(1); pe_done = 1'b0;
    endtask

    task automatic strobe_susp();
        susp_req = 1'b1; cyc(1); susp_req = 1'b0;
    endtask

    // Driver: low pulse of len cycles; pushes the expected reset_busy run, if any.
    task automatic rp_pulse(input int len, input bit long_class);
        exp_run_t e;
        if (len >= MIN_PULSE) begin
            e.len = len - MIN_PULSE + 1 + (long_class ? T_LONG : T_SHORT);
            e.rb  = long_class;
            sb_q.push_back(e);
        end
        rp_pin_n = 1'b0;
        cyc(len);
        rp_pin_n = 1'b1;
        cyc(SYNC + T_LONG + 6);
    endtask

    // Monitor: measures each reset_busy run and compares with the scoreboard.
    int  run_len = 0;
    bit  rb_bad = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (reset_busy) begin
                run_len++;
                if (sb_q.size() != 0 && rb_pulldown != sb_q[0].rb) rb_bad = 1;
                chk_eq("R9 cmd_accept during reset", cmd_accept, 0);
            end else if (run_len > 0) begin
                if (sb_q.size() == 0) begin
                    chk_eq("R5 unexpected reset run", run_len, 0);
                end else begin
                    exp_run_t e;
                    e = sb_q.pop_front();
                    if (e.rb) begin
                        chk_eq("R7 long recovery length", run_len, e.len);
                        chk_eq("R7 busy held during reset", rb_bad, 0);
                    end else begin
                        chk_eq("R6 short recovery length", run_len, e.len);
                        chk_eq("R6 ready during reset", rb_bad, 0);
                    end
                    chk_eq("R7 release with reset end", rb_pulldown, 0);
                end
                run_len = 0;
                rb_bad  = 0;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done_flag) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(SYNC + 1);

        // R1: reset state
        chk_eq("R1 rb_pulldown", rb_pulldown, 0);
        chk_eq("R1 cmd_accept", cmd_accept, 1);
        chk_eq("R1 reset_busy", reset_busy, 0);
        chk_eq("R1 data_corrupt", data_corrupt, 0);
        chk_eq("R1 unprot_ovr", unprot_ovr, 0);

        // R2/R3: program, refused second start, suspend ignored (R4)
        strobe_start(1'b0);
        chk_eq("R2 busy after program start", rb_pulldown, 1);
        chk_eq("R3 refuse while busy", cmd_accept, 0);
        strobe_start(1'b1);
        chk_eq("R3 start ignored while busy", rb_pulldown, 1);
        strobe_susp();
        chk_eq("R4 suspend ignored in program", rb_pulldown, 1);
        chk_eq("R4 still refusing in program", cmd_accept, 0);
        cyc(3);
        strobe_done();
        chk_eq("R2 ready after done", rb_pulldown, 0);
        chk_eq("R2 accept after done", cmd_accept, 1);

        // R4: erase, suspend, resume
        strobe_start(1'b1);
        chk_eq("R2 busy after erase start", rb_pulldown, 1);
        strobe_susp();
        chk_eq("R4 ready in suspend", rb_pulldown, 0);
        chk_eq("R4 accept in suspend", cmd_accept, 1);
        strobe_start(1'b0);
        chk_eq("R4 resume erase busy", rb_pulldown, 1);
        strobe_done();
        chk_eq("R4 ready after resumed erase", rb_pulldown, 0);

        // R5: glitch while idle
        rp_pulse(MIN_PULSE - 1, 1'b0);
        chk_eq("R5 idle glitch reset_busy", reset_busy, 0);
        chk_eq("R5 idle glitch cmd_accept", cmd_accept, 1);

        // R5: glitch during program
        strobe_start(1'b0);
        rp_pulse(MIN_PULSE - 1, 1'b1);
        chk_eq("R5 program survives glitch", rb_pulldown, 1);
        chk_eq("R5 no corruption on glitch", data_corrupt, 0);
        strobe_done();
        chk_eq("R5 program completes", rb_pulldown, 0);

        // R6: accepted reset from idle
        rp_pulse(MIN_PULSE + 2, 1'b0);
        chk_eq("R6 idle reset no corruption", data_corrupt, 0);
        chk_eq("R6 accept after recovery", cmd_accept, 1);

        // R7/R8: reset during program
        strobe_start(1'b0);
        rp_pulse(MIN_PULSE + 2, 1'b1);
        chk_eq("R8 corrupt after program reset", data_corrupt, 1);
        chk_eq("R7 ready after recovery", rb_pulldown, 0);
        chk_eq("R7 accept after recovery", cmd_accept, 1);

        // R8: cleared by start; R7: reset during erase suspend
        strobe_start(1'b1);
        chk_eq("R8 cleared by start", data_corrupt, 0);
        strobe_susp();
        rp_pulse(MIN_PULSE + 2, 1'b1);
        chk_eq("R8 corrupt after suspend reset", data_corrupt, 1);
        cyc(5);
        chk_eq("R8 corrupt stays", data_corrupt, 1);

        // R10: raised-level override
        rp_hv = 1'b1;
        cyc(SYNC + 1);
        chk_eq("R10 override on", unprot_ovr, 1);
        strobe_start(1'b0);
        chk_eq("R10 override during program", unprot_ovr, 1);
        strobe_done();
        rp_hv = 1'b0;
        cyc(SYNC + 1);
        chk_eq("R10 override off", unprot_ovr, 0);

        chk_eq("R6 all expected resets seen", sb_q.size(), 0);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule